// File: doc/BRIEF.md
# CAN Node Low-Power Sequencer

This block governs the power state of a CAN node. A sleeping node has all internal activity stopped and its bus drivers cut off. A dominant level seen on the receive line, or a wake request from the host side, brings the node back. The core restarts first. The block then counts out a programmable oscillator settling time. After that it waits for a run of eleven recessive bit times in a row on the bus, and only then does it reconnect the transmit drivers.

The host asks for sleep through a request input. That request is honoured only when the node is fully active, and it takes effect on the next clock edge. Requests that arrive while the node is already waking are dropped. The block also presents the fixed, lowest-priority identifier that a transmitter sends to wake the other nodes on the bus.

Top module: `can_wake_ctrl`

## Requirements
- R1: After reset the block is asleep: `core_en`, `bus_on` and `osc_ready` are all 0.
- R2: While asleep with the bus recessive (`rx_bit`=1) and no `wake_req`, `core_en` and `bus_on` stay 0, and `bit_tick` pulses have no effect.
- R3: A dominant level (`rx_bit`=0) while asleep passes a two-flop synchronizer, and `core_en` rises on the third clock edge after it is applied. `bus_on` stays 0.
- R4: `wake_req` high at a clock edge while asleep sets `core_en` to 1 after that edge. `bus_on` stays 0.
- R5: Once `core_en` has risen, `osc_ready` goes to 1 exactly `settle_cycles` clock edges later. With `settle_cycles`=0 it is 1 together with `core_en`. `settle_cycles` is captured at the wake edge.
- R6: After `osc_ready`, `bus_on` goes to 1 on the clock edge that follows the edge at which the eleventh consecutive recessive `bit_tick` sample is taken. It stays 0 before that.
- R7: A `bit_tick` sample with a dominant synchronized `rx_bit` during bus synchronization restarts the recessive run from zero.
- R8: `wake_req` or a dominant `rx_bit` during the oscillator wait or bus synchronization is ignored: the settle count is not reloaded, and the timing of `osc_ready` is unchanged.
- R9: `sleep_req` high at an edge while active drives `core_en` and `bus_on` to 0 after that edge.
- R10: `sleep_req` during the oscillator wait or bus synchronization is ignored, and `core_en` stays 1.
- R11: `wake_id` always equals 11'h7EF, transmitted MSB first (bit 4 is the only dominant bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Request to enter sleep (accepted only when active) |
| wake_req | input | 1 | Internal wake condition |
| rx_bit | input | 1 | Asynchronous receive level, 1 = recessive |
| bit_tick | input | 1 | One-cycle strobe at the bit sample point |
| settle_cycles | input | CNT_W | Oscillator settling time in clock cycles |
| core_en | output | 1 | Internal activity enable |
| bus_on | output | 1 | Bus driver enable |
| osc_ready | output | 1 | Oscillator settling time has elapsed |
| wake_id | output | 11 | Identifier for the wake-up message |

## Verification
The wake path is driven in two ways, by `wake_req` and by a dominant receive level. Because the two paths have different latencies, the checks can tell a missing synchronizer stage from a broken wake decode. The settling counter is run with a nonzero count and with zero, and the off-by-one boundary of `osc_ready` is checked on both sides. The bus synchronization is given a run of ten recessive bits broken by a dominant bit and then continued. This separates a counter that restarts on a dominant bit from one that keeps counting or one that only needs eleven recessive bits in total. Wake and sleep requests injected mid-sequence show whether the timer reloads or the state machine accepts a request where it should not.

// File: rtl/can_lp_pkg.sv
// Package: shared state encoding and constants for the CAN low-power sequencer.
// Assumes recessive bus level is logic 1.
package can_lp_pkg;
    typedef enum logic [1:0] {
        ST_SLEEP    = 2'd0,
        ST_OSC_WAIT = 2'd1,
        ST_BUS_SYNC = 2'd2,
        ST_ACTIVE   = 2'd3
    } lp_state_t;

    localparam int unsigned ID_W = 11;
    // Wake-up identifier, MSB first: r r r r r r d r r r r
    localparam logic [ID_W-1:0] WAKE_IDENT = 11'h7EF;
endpackage

// File: rtl/rx_level_sync.sv
// Module: two-flop synchronizer for the asynchronous receive level.
// Assumes: reset value is recessive (1) so reset never looks like bus activity.
module rx_level_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic meta_q;

    // Purpose: shift the raw level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            q_sync <= 1'b1;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/osc_settle_timer.sv
// Module: down-counter for the oscillator settling wait.
// Assumes: load has priority; count holds at zero; zero_o flags expiry.
module osc_settle_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_o
);
    // Purpose: load on wake, then count down to zero while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (load) begin
            cnt_o <= load_val;
        end else if (run && (cnt_o != '0)) begin
            cnt_o <= cnt_o - 1'b1;
        end
    end

    assign zero_o = (cnt_o == '0);

    // R5
    countdown_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt_o != '0) |=> (cnt_o == $past(cnt_o) - 1'b1));
endmodule

// File: rtl/recessive_run_counter.sv
// Module: counts consecutive recessive bit samples during bus synchronization.
// Assumes: clear is held while not synchronizing; count saturates at RUN_LEN.
module recessive_run_counter #(
    parameter int unsigned RUN_LEN = 11,
    localparam int unsigned RUN_W  = $clog2(RUN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic             rx_rec,
    output logic [RUN_W-1:0] run_o,
    output logic             done_o
);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LEN);

    // Purpose: restart on dominant, advance on recessive, at each bit strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            run_o <= '0;
        end else if (tick) begin
            if (!rx_rec)
                run_o <= '0;
            else if (run_o != RUN_MAX)
                run_o <= run_o + 1'b1;
        end
    end

    assign done_o = (run_o == RUN_MAX);

    // R7
    dominant_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && tick && !rx_rec) |=> (run_o == '0));
endmodule

// File: rtl/can_wake_ctrl.sv
// Module: top-level low-power sequencer. Sleep -> oscillator wait -> bus sync -> active.
// Assumes: bit_tick is synchronous to clk; rx_bit may be asynchronous.
module can_wake_ctrl
    import can_lp_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned RUN_LEN = 11,
    localparam int unsigned RUN_W  = $clog2(RUN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             wake_req,
    input  logic             rx_bit,
    input  logic             bit_tick,
    input  logic [CNT_W-1:0] settle_cycles,
    output logic             core_en,
    output logic             bus_on,
    output logic             osc_ready,
    output logic [ID_W-1:0]  wake_id
);
    lp_state_t        state_q, state_d;
    logic             rx_s;
    logic             wake_evt;
    logic             tmr_load;
    logic             tmr_zero;
    logic [CNT_W-1:0] tmr_cnt;
    logic [RUN_W-1:0] run_cnt;
    logic             run_done;

    rx_level_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (rx_bit),
        .q_sync  (rx_s)
    );

    osc_settle_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (settle_cycles),
        .run      (state_q == ST_OSC_WAIT),
        .cnt_o    (tmr_cnt),
        .zero_o   (tmr_zero)
    );

    recessive_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (state_q != ST_BUS_SYNC),
        .tick   (bit_tick),
        .rx_rec (rx_s),
        .run_o  (run_cnt),
        .done_o (run_done)
    );

    // Purpose: wake source is bus activity (dominant) or internal request.
    assign wake_evt = !rx_s || wake_req;
    // Purpose: timer is armed only on the sleep-to-wait transition.
    assign tmr_load = (state_q == ST_SLEEP) && wake_evt;

    // Purpose: next-state decode.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SLEEP:    if (wake_evt)  state_d = ST_OSC_WAIT;
            ST_OSC_WAIT: if (tmr_zero)  state_d = ST_BUS_SYNC;
            ST_BUS_SYNC: if (run_done)  state_d = ST_ACTIVE;
            ST_ACTIVE:   if (sleep_req) state_d = ST_SLEEP;
            default:                    state_d = ST_SLEEP;
        endcase
    end

    // Purpose: state register, reset into sleep.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SLEEP;
        else        state_q <= state_d;
    end

    // Purpose: output decode from state.
    assign core_en   = (state_q != ST_SLEEP);
    assign bus_on    = (state_q == ST_ACTIVE);
    assign osc_ready = core_en && tmr_zero;
    assign wake_id   = WAKE_IDENT;

    // R3
    wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_en) |-> $past(wake_evt));
    // R6
    onbus_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_on) |-> ($past(run_cnt) == RUN_W'(RUN_LEN)));
    // R8
    no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OSC_WAIT && $past(state_q) == ST_OSC_WAIT && $past(tmr_cnt) != '0)
            |-> (tmr_cnt == $past(tmr_cnt) - 1'b1));
    // R9
    sleep_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_on && sleep_req) |=> (!core_en && !bus_on));
    // R10
    sleep_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_en && !bus_on) |=> core_en);
endmodule

// File: tb/can_wake_ctrl_test.sv
// Scoreboard bench: the driver pushes expected output sets, the monitor compares.
module can_wake_ctrl_test;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sleep_req = 1'b0;
    logic             wake_req = 1'b0;
    logic             rx_bit = 1'b1;
    logic             bit_tick = 1'b0;
    logic [CNT_W-1:0] settle_cycles = '0;
    logic             core_en, bus_on, osc_ready;
    logic [10:0]      wake_id;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        string tag;
        logic  core;
        logic  bus;
        logic  rdy;
    } exp_t;

    exp_t sb[$];
    event pushed;

    always #4 clk = ~clk;   // 125 MHz

    can_wake_ctrl #(.CNT_W(CNT_W), .RUN_LEN(11)) uut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
        .rx_bit(rx_bit), .bit_tick(bit_tick), .settle_cycles(settle_cycles),
        .core_en(core_en), .bus_on(bus_on), .osc_ready(osc_ready), .wake_id(wake_id)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input logic c, input logic b, input logic r);
        exp_t e;
        e.tag = tag; e.core = c; e.bus = b; e.rdy = r;
        sb.push_back(e);
        -> pushed;
        #0;
    endtask

    // one bit time: settle rx through synchronizer, then strobe
    task automatic send_bit(input logic b);
        rx_bit = b;
        step(3);
        bit_tick = 1'b1;
        step(1);
        bit_tick = 1'b0;
    endtask

    // Monitor: pop and compare every pushed expectation (R11 checked on each)
    initial begin
        forever begin
            @(pushed);
            while (sb.size() != 0) begin
                exp_t e;
                e = sb.pop_front();
                n_cmp++;
                if (core_en !== e.core || bus_on !== e.bus || osc_ready !== e.rdy) begin
                    n_bad++;
                    $display("FAIL %s: core/bus/rdy = %b%b%b expected %b%b%b",
                             e.tag, core_en, bus_on, osc_ready, e.core, e.bus, e.rdy);
                end
                n_cmp++;
                if (wake_id !== 11'h7EF) begin
                    n_bad++;
                    $display("FAIL R11: wake_id = %h expected 7ef", wake_id);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Driver
    initial begin
        step(4);
        expect_out("R1 in reset", 0, 0, 0);
        rst_n = 1'b1;
        step(1);
        expect_out("R1 after reset", 0, 0, 0);

        // R2: ticks on a quiet bus do nothing
        send_bit(1'b1);
        send_bit(1'b1);
        expect_out("R2 quiet sleep", 0, 0, 0);

        // R4 + R5 with settle 4
        settle_cycles = 16'd4;
        wake_req = 1'b1;
        step(1);
        wake_req = 1'b0;
        expect_out("R4 wake_req", 1, 0, 0);
        step(3);
        expect_out("R5 one before settle", 1, 0, 0);
        step(1);
        expect_out("R5 settle reached", 1, 0, 1);
        step(1);
        // R10: sleep in bus sync ignored
        sleep_req = 1'b1;
        step(1);
        sleep_req = 1'b0;
        expect_out("R10 sleep in sync", 1, 0, 1);

        // R7: ten recessive, a dominant, ten recessive
        for (int i = 0; i < 10; i++) send_bit(1'b1);
        send_bit(1'b0);
        for (int i = 0; i < 10; i++) send_bit(1'b1);
        expect_out("R7 run restarted", 1, 0, 1);
        send_bit(1'b1);
        expect_out("R6 edge of eleventh", 1, 0, 1);
        step(1);
        expect_out("R6 onbus", 1, 1, 1);

        // R9: sleep from active
        sleep_req = 1'b1;
        step(1);
        sleep_req = 1'b0;
        expect_out("R9 sleep", 0, 0, 0);

        // R3: dominant wakes after the synchronizer
        settle_cycles = 16'd10;
        rx_bit = 1'b0;
        step(2);
        expect_out("R3 two edges", 0, 0, 0);
        step(1);
        rx_bit = 1'b1;
        expect_out("R3 third edge", 1, 0, 0);

        // R8 / R10: wake and sleep events mid-wait
        step(3);
        wake_req = 1'b1; rx_bit = 1'b0; sleep_req = 1'b1;
        step(1);
        wake_req = 1'b0; rx_bit = 1'b1; sleep_req = 1'b0;
        expect_out("R10 sleep in osc wait", 1, 0, 0);
        step(5);
        expect_out("R8 no reload before", 1, 0, 0);
        step(1);
        expect_out("R8 ready on time", 1, 0, 1);
        step(1);
        for (int i = 0; i < 11; i++) send_bit(1'b1);
        step(1);
        expect_out("R6 second onbus", 1, 1, 1);

        // R5 zero settle count
        sleep_req = 1'b1;
        step(1);
        sleep_req = 1'b0;
        settle_cycles = 16'd0;
        wake_req = 1'b1;
        step(1);
        wake_req = 1'b0;
        expect_out("R5 zero settle", 1, 0, 1);

        #1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule